// File: doc/BRIEF.md
# Dual Countdown Timer Register Window

This block places two identical countdown timers behind one word-wide register port that spans a 4 KB byte window with a 12-bit byte address. The lowest 64 bytes hold the timers: the first 32 bytes belong to timer 0 and the next 32 bytes to timer 1. Both halves use the same register layout, so software drives either timer with the same code and a different base. Each timer counts down on its own tick-enable input, so the two timers can run at unrelated rates. A timer can free-run, reload from a stored value, or stop at zero. It has a prescaler and a narrow (16-bit) or wide counting width.

The top 32 bytes of the window return eight fixed identification bytes, one per word. Every other address reads as zero, including the two test-control words. Each timer raises its interrupt when it counts down to zero, and the block ORs the two interrupts onto one request line.

Top module: `dual_timer_top`

## Requirements
- R1: Byte addresses 0x000-0x01F reach timer 0 and 0x020-0x03F reach timer 1. Bits [4:2] select the register: 0 load, 1 current count (read only), 2 control, 3 interrupt clear (write only), 4 raw status, 5 masked status, 6 background load. Address bits [1:0] are ignored everywhere.
- R2: The control register is 8 bits and reads back as written. Bit 0 selects single-shot, bit 1 selects the wide counter (otherwise the counter is 16 bits), bits [3:2] set the prescale (0 gives /1, 1 gives /16, 2 gives /256, 3 gives /1), bit 5 enables the interrupt, bit 6 selects periodic and bit 7 enables the timer. While bit 7 is clear the count never changes on ticks.
- R3: Each prescaled tick on an enabled timer with a nonzero count lowers the count by one. The tick that takes the count from 1 to 0 sets the raw status.
- R4: On a prescaled tick at count 0, a single-shot timer stays at 0 (single-shot takes precedence over periodic). A periodic timer reloads the load value. Otherwise the count becomes all ones of the current width (0xFFFF narrow, 0xFFFFFFFF wide).
- R5: Writing the load register sets both the load value and the count (the count is masked to the current width). Writing the background load sets only the load value. Writes to the count register are ignored.
- R6: Writing the interrupt clear register clears the raw status. If a countdown to zero happens in the same cycle, the status stays set.
- R7: The masked status reads as raw status AND interrupt enable. The `irq` output is the OR of both timers' masked status.
- R8: Byte addresses 0xFE0-0xFFC return, in address order, 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in bits [7:0], with all upper bits zero.
- R9: Reads of every other address return 0. This covers 0xF00 and 0xF04, 0x040-0xFDC, and register index 7 of each timer. Writes outside 0x000-0x03F change nothing.
- R10: Read data appears on `rdata` at the clock edge that samples `rd_en`. It holds until the next read.
- R11: After reset each timer has load 0, count all ones, control 0x20 and raw status 0. `irq` and `rdata` are 0.
- R12: Every control write restarts that timer's prescaler from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| tick_en | input | 2 | per-timer count enable, bit i drives timer i |
| wr_en | input | 1 | register write strobe |
| rd_en | input | 1 | register read strobe |
| addr | input | 12 | byte address within the window |
| wdata | input | DATA_W | write data |
| rdata | output | DATA_W | registered read data |
| irq | output | 1 | combined timer interrupt |

## Verification
A register write takes effect at the clock edge that samples it, so a read issued in the following cycle already sees it. Read data is due exactly one edge after `rd_en` is sampled. The bench queues each expected word when it drives the read and compares it at the falling edge after that sampling edge. A tick held high across n rising edges changes the count n times. `irq` is a combinational function of registered state, so the bench samples it at the falling edge after the last tick or write edge. The prescaler cases count ticks exactly, to the boundary edge: 15 and 16 ticks at /16, and 10 + 10 ticks around a control rewrite.

// File: rtl/dtw_pkg.sv
package dtw_pkg;

   typedef enum logic [2:0] {
      REG_LOAD   = 3'd0,
      REG_VALUE  = 3'd1,
      REG_CTRL   = 3'd2,
      REG_CLEAR  = 3'd3,
      REG_RAW    = 3'd4,
      REG_MASKED = 3'd5,
      REG_BGLOAD = 3'd6,
      REG_NONE   = 3'd7
   } reg_idx_e;

   typedef struct packed {
      logic       run;
      logic       periodic;
      logic       irq_en;
      logic       spare;
      logic [1:0] scale;
      logic       wide;
      logic       single;
   } ctrl_t;

   localparam ctrl_t CTRL_RESET = ctrl_t'(8'h20);

   function automatic logic [7:0] id_byte(input logic [2:0] idx);
      logic [7:0] b;
      case (idx)
         3'd0:    b = 8'h04;
         3'd1:    b = 8'h18;
         3'd2:    b = 8'h14;
         3'd3:    b = 8'h00;
         3'd4:    b = 8'h0D;
         3'd5:    b = 8'hF0;
         3'd6:    b = 8'h05;
         default: b = 8'hB1;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/dtw_prescale.sv
module dtw_prescale #(
   parameter int LOG_A = 4,
   parameter int LOG_B = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic       run,
   input  logic       tick,
   input  logic [1:0] scale,
   output logic       fire
);
   localparam int PW = LOG_B;
   localparam logic [PW-1:0] LIM_A = PW'((1 << LOG_A) - 1);
   localparam logic [PW-1:0] LIM_B = PW'((1 << LOG_B) - 1);

   logic [PW-1:0] pcnt_q;
   logic [PW-1:0] limit;

   always_comb begin
      case (scale)
         2'd1:    limit = LIM_A;
         2'd2:    limit = LIM_B;
         default: limit = '0;
      endcase
   end

   assign fire = run && tick && (pcnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt_q <= '0;
      end else if (restart) begin
         pcnt_q <= '0;
      end else if (run && tick) begin
         pcnt_q <= fire ? '0 : pcnt_q + PW'(1);
      end
   end
endmodule

// File: rtl/dtw_timer.sv
module dtw_timer
   import dtw_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int NARROW_W = 16,
   parameter int LOG_A    = 4,
   parameter int LOG_B    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              we,
   input  reg_idx_e          idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] load_o,
   output logic [DATA_W-1:0] val_o,
   output ctrl_t             ctrl_o,
   output logic              raw_o,
   output logic              irq_o
);
   localparam logic [DATA_W-1:0] NARROW_MASK =
      {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   logic [DATA_W-1:0] cnt_q, cnt_d, load_q, mask, cnt_m;
   ctrl_t             ctrl_q;
   logic              raw_q, raw_set, fire;
   logic              wr_ctrl, wr_load, wr_bg, wr_clr;

   assign wr_ctrl = we && (idx == REG_CTRL);
   assign wr_load = we && (idx == REG_LOAD);
   assign wr_bg   = we && (idx == REG_BGLOAD);
   assign wr_clr  = we && (idx == REG_CLEAR);

   dtw_prescale #(.LOG_A(LOG_A), .LOG_B(LOG_B)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (wr_ctrl),
      .run     (ctrl_q.run),
      .tick    (tick),
      .scale   (ctrl_q.scale),
      .fire    (fire)
   );

   assign mask  = ctrl_q.wide ? '1 : NARROW_MASK;
   assign cnt_m = cnt_q & mask;

   always_comb begin
      cnt_d   = cnt_q;
      raw_set = 1'b0;
      if (fire) begin
         if (cnt_m != '0) begin
            cnt_d   = cnt_m - ONE;
            raw_set = (cnt_m == ONE);
         end else if (ctrl_q.single) begin
            cnt_d = '0;
         end else if (ctrl_q.periodic) begin
            cnt_d = load_q & mask;
         end else begin
            cnt_d = mask;
         end
      end
      if (wr_load) begin
         cnt_d = wdata & mask;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '1;
         load_q <= '0;
         ctrl_q <= CTRL_RESET;
         raw_q  <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         if (wr_load || wr_bg) begin
            load_q <= wdata;
         end
         if (wr_ctrl) begin
            ctrl_q <= ctrl_t'(wdata[7:0]);
         end
         if (raw_set) begin
            raw_q <= 1'b1;
         end else if (wr_clr) begin
            raw_q <= 1'b0;
         end
      end
   end

   assign load_o = load_q;
   assign val_o  = cnt_m;
   assign ctrl_o = ctrl_q;
   assign raw_o  = raw_q;
   assign irq_o  = raw_q && ctrl_q.irq_en;
endmodule

// File: rtl/dtw_decode.sv
module dtw_decode
   import dtw_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              tmr_hit,
   output logic              tmr_sel,
   output reg_idx_e          idx,
   output logic              id_hit,
   output logic [2:0]        id_idx
);
   localparam int HI_W = ADDR_W - 5;

   assign tmr_hit = (addr[ADDR_W-1:6] == '0);
   assign tmr_sel = addr[5];
   assign idx     = reg_idx_e'(addr[4:2]);
   assign id_hit  = (addr[ADDR_W-1:5] == {HI_W{1'b1}});
   assign id_idx  = addr[4:2];
endmodule

// File: rtl/dual_timer_top.sv
module dual_timer_top
   import dtw_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int NARROW_W = 16,
   parameter int LOG_A    = 4,
   parameter int LOG_B    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        tick_en,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [11:0]       addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq
);
   localparam int ADDR_W = 12;
   localparam int N_TMR  = 2;

   if (NARROW_W < 8 || NARROW_W >= DATA_W) begin : g_bad_width
      $error("dual_timer_top: NARROW_W must be in [8, DATA_W)");
   end
   if (LOG_A < 1 || LOG_B <= LOG_A) begin : g_bad_scale
      $error("dual_timer_top: need 1 <= LOG_A < LOG_B");
   end

   logic                         tmr_hit, tmr_sel, id_hit;
   reg_idx_e                     idx;
   logic [2:0]                   id_idx;
   logic [N_TMR-1:0][DATA_W-1:0] t_load, t_val;
   ctrl_t                        t_ctrl [N_TMR];
   logic [N_TMR-1:0]             t_raw, t_irq, t_run;
   logic [DATA_W-1:0]            rd_next, rdata_q;

   dtw_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr    (addr),
      .tmr_hit (tmr_hit),
      .tmr_sel (tmr_sel),
      .idx     (idx),
      .id_hit  (id_hit),
      .id_idx  (id_idx)
   );

   for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
      logic we_i;
      assign we_i = wr_en && tmr_hit && (tmr_sel == 1'(i));
      dtw_timer #(
         .DATA_W   (DATA_W),
         .NARROW_W (NARROW_W),
         .LOG_A    (LOG_A),
         .LOG_B    (LOG_B)
      ) u_tmr (
         .clk    (clk),
         .rst_n  (rst_n),
         .tick   (tick_en[i]),
         .we     (we_i),
         .idx    (idx),
         .wdata  (wdata),
         .load_o (t_load[i]),
         .val_o  (t_val[i]),
         .ctrl_o (t_ctrl[i]),
         .raw_o  (t_raw[i]),
         .irq_o  (t_irq[i])
      );
      assign t_run[i] = t_ctrl[i].run;
   end

   always_comb begin
      rd_next = '0;
      if (tmr_hit) begin
         case (idx)
            REG_LOAD, REG_BGLOAD: rd_next = t_load[tmr_sel];
            REG_VALUE:            rd_next = t_val[tmr_sel];
            REG_CTRL:             rd_next = DATA_W'(t_ctrl[tmr_sel]);
            REG_RAW:              rd_next = DATA_W'(t_raw[tmr_sel]);
            REG_MASKED:           rd_next = DATA_W'(t_irq[tmr_sel]);
            default:              rd_next = '0;
         endcase
      end else if (id_hit) begin
         rd_next = DATA_W'(id_byte(id_idx));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (rd_en) begin
         rdata_q <= rd_next;
      end
   end

   assign rdata = rdata_q;
   assign irq   = |t_irq;
endmodule

// File: rtl/dtw_checker.sv
module dtw_checker #(
   parameter int DATA_W = 32
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    wr_en,
   input logic                    rd_en,
   input logic [11:0]             addr,
   input logic [DATA_W-1:0]       rdata,
   input logic                    irq,
   input logic [1:0]              t_run,
   input logic [1:0][DATA_W-1:0]  t_val
);
   // R9: everything between the timer slots and the identification words reads zero
   a_r9_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr[11:6] != 6'd0 && addr[11:5] != 7'h7F) |=> (rdata == '0));

   // R8: identification words carry data only in the low byte
   a_r8_id_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr[11:5] == 7'h7F) |=> (rdata[DATA_W-1:8] == '0));

   // R10: read data holds between reads
   a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));

   // R6/R7: the request line can only drop after a register write
   a_r7_irq_fall_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(wr_en));

   for (genvar t = 0; t < 2; t++) begin : g_t
      // R2: a stopped timer holds its count when no write arrives
      a_r2_stopped_stable: assert property (@(posedge clk) disable iff (!rst_n)
         (!t_run[t] && !wr_en) |=> $stable(t_val[t]));
   end
endmodule

bind dual_timer_top dtw_checker #(.DATA_W(DATA_W)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .wr_en (wr_en),
   .rd_en (rd_en),
   .addr  (addr),
   .rdata (rdata),
   .irq   (irq),
   .t_run (t_run),
   .t_val (t_val)
);

// File: tb/sim_dual_timer_top.sv
module sim_dual_timer_top;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    tick_en = 2'b00;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [11:0]   addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          irq;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;
   logic rd_seen = 1'b0;

   logic [DW-1:0] exp_q [$];
   string         tag_q [$];

   always #10 clk = ~clk;

   dual_timer_top u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .addr    (addr),
      .wdata   (wdata),
      .rdata   (rdata),
      .irq     (irq)
   );

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: read data is due one rising edge after rd_en was sampled
   always @(posedge clk) rd_seen <= rd_en;
   always @(negedge clk) begin
      if (rd_seen && exp_q.size() > 0) begin
         logic [DW-1:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(t, rdata, e);
      end
   end

   task automatic wr(input logic [11:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [DW-1:0] e, input string tag);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic tick(input logic [1:0] m, input int n);
      @(negedge clk);
      tick_en = m;
      repeat (n) @(negedge clk);
      tick_en = 2'b00;
   endtask

   task automatic chk_irq(input logic e, input string tag);
      @(negedge clk);
      check(tag, DW'(irq), DW'(e));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R10 watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check("R11 rdata", rdata, '0);
      check("R11 irq", DW'(irq), '0);
      rd(12'h008, 32'h20, "R11 ctrl");
      rd(12'h004, 32'h0000FFFF, "R11 count");
      rd(12'h000, 32'h0, "R11 load");
      rd(12'h030, 32'h0, "R11 raw t1");
      // R8 identification words
      for (int i = 0; i < 8; i++) begin
         logic [7:0] idv [8] = '{8'h04, 8'h18, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
         rd(12'hFE0 + 12'(4 * i), DW'(idv[i]), "R8 id word");
      end
      rd(12'hFE3, 32'h04, "R1 R8 low bits ignored");
      // R9 holes
      rd(12'hF00, 32'h0, "R9 test ctrl");
      rd(12'hF04, 32'h0, "R9 test out");
      rd(12'h040, 32'h0, "R9 hole");
      rd(12'h01C, 32'h0, "R9 index 7");
      rd(12'hFDC, 32'h0, "R9 below id");
      wr(12'h040, 32'hDEAD);
      wr(12'hF00, 32'h1);
      rd(12'h000, 32'h0, "R9 write ignored t0");
      rd(12'h020, 32'h0, "R9 write ignored t1");
      rd(12'h008, 32'h20, "R9 write ignored ctrl");
      // R5 count register is read only
      wr(12'h004, 32'h55);
      rd(12'h004, 32'h0000FFFF, "R5 count write ignored");
      // R3 R4 periodic wide on timer 0
      wr(12'h000, 32'd3);
      rd(12'h004, 32'd3, "R5 load sets count");
      wr(12'h008, 32'hE2);
      rd(12'h008, 32'hE2, "R2 ctrl readback");
      tick(2'b01, 2);
      rd(12'h004, 32'd1, "R3 decrement");
      chk_irq(1'b0, "R3 irq before zero");
      tick(2'b01, 1);
      chk_irq(1'b1, "R3 R7 irq at zero");
      rd(12'h010, 32'd1, "R3 raw");
      rd(12'h014, 32'd1, "R7 masked");
      tick(2'b01, 1);
      rd(12'h004, 32'd3, "R4 periodic reload");
      wr(12'h018, 32'd7);
      rd(12'h004, 32'd3, "R5 bg load leaves count");
      rd(12'h000, 32'd7, "R5 bg load value");
      wr(12'h00C, 32'h1);
      chk_irq(1'b0, "R6 clear");
      rd(12'h010, 32'd0, "R6 raw cleared");
      // R6 set beats clear: count 3 -> 1, then clear together with final tick
      tick(2'b01, 2);
      @(negedge clk);
      wr_en = 1'b1; addr = 12'h00C; tick_en = 2'b01;
      @(negedge clk);
      wr_en = 1'b0; tick_en = 2'b00;
      rd(12'h010, 32'd1, "R6 set wins over clear");
      wr(12'h00C, 32'h1);
      chk_irq(1'b0, "R6 second clear");
      // R2 stopped timer
      wr(12'h008, 32'h62);
      wr(12'h000, 32'd9);
      tick(2'b01, 3);
      rd(12'h004, 32'd9, "R2 stopped holds");
      // R2 R12 prescale /16
      wr(12'h008, 32'hE6);
      tick(2'b01, 15);
      rd(12'h004, 32'd9, "R2 prescale 15 ticks");
      tick(2'b01, 1);
      rd(12'h004, 32'd8, "R2 prescale 16th tick");
      tick(2'b01, 10);
      wr(12'h008, 32'hE6);
      tick(2'b01, 10);
      rd(12'h004, 32'd8, "R12 prescaler restart");
      tick(2'b01, 6);
      rd(12'h004, 32'd7, "R12 after restart");
      // timer 1 narrow free running, interrupt disabled
      wr(12'h028, 32'h80);
      wr(12'h020, 32'h12345);
      rd(12'h024, 32'h2345, "R5 narrow mask");
      rd(12'h020, 32'h12345, "R5 load full width");
      wr(12'h020, 32'd2);
      tick(2'b10, 2);
      rd(12'h030, 32'd1, "R3 t1 raw");
      rd(12'h034, 32'd0, "R7 masked off");
      chk_irq(1'b0, "R7 irq masked");
      tick(2'b10, 1);
      rd(12'h024, 32'h0000FFFF, "R4 free run narrow");
      rd(12'h004, 32'd7, "R1 t0 untouched by t1");
      wr(12'h028, 32'hA0);
      chk_irq(1'b1, "R7 enable shows pending");
      wr(12'h02C, 32'h1);
      chk_irq(1'b0, "R6 t1 clear");
      // R4 single-shot
      wr(12'h028, 32'hE3);
      wr(12'h020, 32'd1);
      tick(2'b10, 1);
      chk_irq(1'b1, "R3 single shot zero");
      tick(2'b10, 3);
      rd(12'h024, 32'd0, "R4 single shot holds");
      // R7 OR of both timers
      wr(12'h000, 32'd1);
      wr(12'h008, 32'hE2);
      tick(2'b01, 1);
      wr(12'h02C, 32'h1);
      chk_irq(1'b1, "R7 t0 alone");
      wr(12'h00C, 32'h1);
      chk_irq(1'b0, "R7 both clear");
      // R10 hold
      rd(12'hFE4, 32'h18, "R10 read");
      repeat (4) @(negedge clk);
      check("R10 hold", rdata, 32'h18);
      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         total++; bad++;
         $display("FAIL R10 pending reads actual=%0d expected=0", exp_q.size());
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule